// File: doc/BRIEF.md
# Half-Bridge Soft-Ramp Output Sequencer

This block controls start-up and shutdown for one pair of half-bridge power outputs. Each output has a DC-blocking capacitor in series with it. When the pair leaves reset, the sequencer can raise the output bias slowly from ground to mid-supply. This lets the series capacitor charge before PWM switching is allowed. When the pair reset is asserted again, the bias falls back to ground, much more slowly, and only then are the outputs released to high impedance.

The bias is sent to an external bias DAC as an N-bit level code. Mid-scale is the bias point. The code moves by one LSB each time a prescaler expires, and the rising and falling directions each have their own prescaler limit. If the reset input changes direction partway through a ramp, the ramp turns around at its current level. The soft ramp is used only when the ramp strap is set and the latched output configuration is one of the quad half-bridge codes. In every other configuration the outputs go straight from high impedance to switching and back.

The configuration code is latched on the clock edge that takes the pair out of its idle state. Its upper bit selects internal inversion of the second input of each bridge.

Top module: `soft_ramp_seq`

## Requirements
- R1: While the pair is idle (pair reset held low after any ramp has finished), `out_drive` is 0, `low_power` is 1, `sw_enable` is 0, `bias_level` is 0 and `inv_second` is 0.
- R2: `cfg_code` and `ramp_strap` are latched only on the edge at which the pair leaves idle. After that edge, `inv_second` equals the latched `cfg_code[2]` while `out_drive` is 1, and later changes on `cfg_code` have no effect until the pair is idle again.
- R3: The soft ramp is used only if `ramp_strap` is 1 and the latched `cfg_code[1:0]` is 2'b11 (codes 011 and 111). All other codes, or a strap of 0, select bypass.
- R4: In ramp mode, the edge that leaves idle sets `out_drive` to 1 with `bias_level` 0. After that, `bias_level` rises by one every UP_DIV cycles until it reaches mid-scale, 2**(LEVEL_W-1).
- R5: `sw_enable` is 1 only when the pair reset is high, `mod_valid` is high and the pair is running. In ramp mode, running means `bias_level` has reached mid-scale. Dropping the pair reset or `mod_valid` clears `sw_enable` in the same cycle.
- R6: In ramp mode, asserting the pair reset makes `bias_level` fall by one every DN_DIV cycles. On the edge at which it reaches 0, `out_drive` drops to 0 and `low_power` rises to 1.
- R7: In bypass, one edge with the pair reset high gives `out_drive` 1 with `bias_level` 0, and one edge with it low gives `out_drive` 0.
- R8: A ramp that reverses partway continues from its current level, with the prescaler restarted. A fall that starts at level 0 reaches idle on the next edge.
- R9: `bias_level` never exceeds mid-scale and changes by at most one per cycle. It rises only after an edge with the pair reset high and falls only after an edge with it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset of the sequencer |
| pair_rst_n | input | 1 | Active-low reset for the output pair |
| ramp_strap | input | 1 | 1 enables the soft ramp (honoured in quad half-bridge codes only) |
| cfg_code | input | 3 | Output configuration code; bit 2 selects inversion |
| mod_valid | input | 1 | Modulator output is valid |
| bias_level | output | LEVEL_W | Ramp code for the bias DAC; mid-scale is the bias point |
| out_drive | output | 1 | 1 drives the outputs, 0 puts them at high impedance |
| sw_enable | output | 1 | Enables PWM switching of the outputs |
| low_power | output | 1 | Pair is idle in low-power mode |
| inv_second | output | 1 | Invert the second input of each bridge |

## Verification
The bound checker watches properties that hold on every cycle. The level never goes above mid-scale and moves by at most one step per cycle. Each rise or fall of the level, and each fall of the output drive, must follow the matching value of the pair reset. Switching is never enabled without the reset high, the modulator valid and the outputs driven, the inversion bit does not change while the pair is active, and the idle state always comes with a zero level. Some behaviour only the bench's scenarios can show: the exact prescaler cadence in each direction, the cycle on which switching first starts, which codes bypass the ramp, reversal partway through a ramp, and the latching of the configuration against later input changes. The bench shows these by comparing against its cycle-by-cycle model and by checking fixed expected values.

// File: rtl/soft_ramp_pkg.sv
// Shared types for the soft-ramp output sequencer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package soft_ramp_pkg;

    // Sequencer phase of the output pair
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // high impedance, low power
        PH_RISE = 2'd1,   // bias ramping toward mid-scale
        PH_RUN  = 2'd2,   // switching allowed
        PH_FALL = 2'd3    // bias ramping toward ground
    } phase_t;

endpackage

// File: rtl/srs_mode_decode.sv
// Decodes the output configuration code into the ramp qualifier and the
// inversion select. Purely combinational; the caller latches the result.
// Assumes: code bits [1:0] == 2'b11 mark the quad half-bridge layouts.
module srs_mode_decode (
    input  logic       ramp_strap,
    input  logic [2:0] code,
    output logic       use_ramp,
    output logic       invert
);
    // R3: ramp honoured only for the quad half-bridge codes
    always_comb begin
        use_ramp = ramp_strap && (code[1:0] == 2'b11);
        invert   = code[2];
    end
endmodule

// File: rtl/srs_prescaler.sv
// Step prescaler with separate limits for the rising and falling directions.
// Produces a one-cycle tick every UP_DIV (or DN_DIV) enabled cycles.
// Assumes: en is dropped for a cycle whenever the direction changes.
module srs_prescaler #(
    parameter int UP_DIV = 4,
    parameter int DN_DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic dir_down,
    output logic tick
);
    localparam int MAX_DIV = (UP_DIV > DN_DIV) ? UP_DIV : DN_DIV;
    localparam int CNT_W   = $clog2(MAX_DIV + 1);
    localparam logic [CNT_W-1:0] UP_LAST = CNT_W'(UP_DIV - 1);
    localparam logic [CNT_W-1:0] DN_LAST = CNT_W'(DN_DIV - 1);

    logic [CNT_W-1:0] cnt;

    // Terminal count for the active direction
    always_comb begin
        tick = en && (cnt == (dir_down ? DN_LAST : UP_LAST));
    end

    // Count enabled cycles, restart on tick or when disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !en || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/soft_ramp_seq.sv
// Soft-ramp output sequencer for one pair of half-bridge outputs.
// Raises the bias code from 0 to mid-scale after the pair reset is released
// and lowers it back to 0 after the pair reset is asserted, one LSB per
// prescaler tick, before switching starts or before going to high impedance.
// Codes outside the quad half-bridge set, or a cleared strap, bypass the ramp.
// Assumes: pair_rst_n, ramp_strap, cfg_code and mod_valid are synchronous to clk.
module soft_ramp_seq
    import soft_ramp_pkg::*;
#(
    parameter int LEVEL_W = 10,
    parameter int UP_DIV  = 4,
    parameter int DN_DIV  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pair_rst_n,
    input  logic               ramp_strap,
    input  logic [2:0]         cfg_code,
    input  logic               mod_valid,
    output logic [LEVEL_W-1:0] bias_level,
    output logic               out_drive,
    output logic               sw_enable,
    output logic               low_power,
    output logic               inv_second
);
    localparam logic [LEVEL_W-1:0] BIAS_CODE = LEVEL_W'(1) << (LEVEL_W - 1);
    localparam logic [LEVEL_W-1:0] BIAS_PRE  = BIAS_CODE - 1'b1;
    localparam logic [LEVEL_W-1:0] ONE_CODE  = LEVEL_W'(1);

    phase_t             phase, phase_n;
    logic [LEVEL_W-1:0] level_n;
    logic               ramp_q, inv_q;
    logic               dec_ramp, dec_inv;
    logic               load_cfg, reverse, step;

    srs_mode_decode u_dec (
        .ramp_strap (ramp_strap),
        .code       (cfg_code),
        .use_ramp   (dec_ramp),
        .invert     (dec_inv)
    );

    srs_prescaler #(.UP_DIV(UP_DIV), .DN_DIV(DN_DIV)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       ((phase == PH_RISE || phase == PH_FALL) && !reverse),
        .dir_down (phase == PH_FALL),
        .tick     (step)
    );

    // Next phase and next level from the pair reset and prescaler tick
    always_comb begin
        phase_n  = phase;
        level_n  = bias_level;
        load_cfg = 1'b0;
        reverse  = 1'b0;
        unique case (phase)
            PH_IDLE: begin
                level_n = '0;
                if (pair_rst_n) begin
                    load_cfg = 1'b1;                         // R2
                    phase_n  = dec_ramp ? PH_RISE : PH_RUN;  // R3, R7
                end
            end
            PH_RISE: begin
                if (!pair_rst_n) begin
                    phase_n = PH_FALL;                       // R8
                    reverse = 1'b1;
                end else if (step) begin
                    level_n = bias_level + 1'b1;             // R4
                    if (bias_level == BIAS_PRE) phase_n = PH_RUN;
                end
            end
            PH_RUN: begin
                if (!pair_rst_n) begin
                    if (ramp_q) begin
                        phase_n = PH_FALL;                   // R6
                        reverse = 1'b1;
                    end else begin
                        phase_n = PH_IDLE;                   // R7
                        level_n = '0;
                    end
                end
            end
            PH_FALL: begin
                if (pair_rst_n) begin
                    phase_n = PH_RISE;                       // R8
                    reverse = 1'b1;
                end else if (bias_level == '0) begin
                    phase_n = PH_IDLE;
                end else if (step) begin
                    level_n = bias_level - 1'b1;             // R6
                    if (bias_level == ONE_CODE) phase_n = PH_IDLE;
                end
            end
            default: phase_n = PH_IDLE;
        endcase
    end

    // State, level and latched configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            bias_level <= '0;
            ramp_q     <= 1'b0;
            inv_q      <= 1'b0;
        end else begin
            phase      <= phase_n;
            bias_level <= level_n;
            if (load_cfg) begin
                ramp_q <= dec_ramp;
                inv_q  <= dec_inv;
            end
        end
    end

    // Output decode; switching also gated by the live inputs (R5)
    always_comb begin
        out_drive  = (phase != PH_IDLE);
        low_power  = (phase == PH_IDLE);                     // R1
        sw_enable  = (phase == PH_RUN) && pair_rst_n && mod_valid;
        inv_second = inv_q && out_drive;
    end
endmodule

// File: rtl/srs_checker.sv
// Property checker for soft_ramp_seq, attached by bind.
// Assumes: it sees only the ports of the sequencer.
module srs_checker #(
    parameter int LEVEL_W = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pair_rst_n,
    input logic               mod_valid,
    input logic [LEVEL_W-1:0] bias_level,
    input logic               out_drive,
    input logic               sw_enable,
    input logic               low_power,
    input logic               inv_second
);
    localparam logic [LEVEL_W-1:0] MID = LEVEL_W'(1) << (LEVEL_W - 1);

    // R9
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bias_level <= MID);

    // R9
    level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bias_level == $past(bias_level)) ||
        (bias_level == LEVEL_W'($past(bias_level) + 1'b1)) ||
        (LEVEL_W'(bias_level + 1'b1) == $past(bias_level)));

    // R4
    rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bias_level > $past(bias_level)) |-> $past(pair_rst_n));

    // R6
    fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bias_level < $past(bias_level)) |-> !$past(pair_rst_n));

    // R6
    hiz_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_drive) |-> !$past(pair_rst_n));

    // R5
    switch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_enable |-> (pair_rst_n && mod_valid && out_drive));

    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_power |-> (bias_level == '0 && !sw_enable && !inv_second));

    // R2
    inv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_drive && $past(out_drive)) |-> $stable(inv_second));
endmodule

bind soft_ramp_seq srs_checker #(.LEVEL_W(LEVEL_W)) u_srs_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pair_rst_n (pair_rst_n),
    .mod_valid  (mod_valid),
    .bias_level (bias_level),
    .out_drive  (out_drive),
    .sw_enable  (sw_enable),
    .low_power  (low_power),
    .inv_second (inv_second)
);

// File: tb/tb_soft_ramp_seq.sv
module tb_soft_ramp_seq;
    localparam int LW  = 6;
    localparam int UPD = 3;
    localparam int DND = 5;
    localparam int MID = 1 << (LW - 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pair_rst_n = 1'b0;
    logic          ramp_strap = 1'b0;
    logic [2:0]    cfg_code = 3'b000;
    logic          mod_valid = 1'b0;
    logic [LW-1:0] bias_level;
    logic          out_drive, sw_enable, low_power, inv_second;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    soft_ramp_seq #(.LEVEL_W(LW), .UP_DIV(UPD), .DN_DIV(DND)) dut (
        .clk(clk), .rst_n(rst_n), .pair_rst_n(pair_rst_n),
        .ramp_strap(ramp_strap), .cfg_code(cfg_code), .mod_valid(mod_valid),
        .bias_level(bias_level), .out_drive(out_drive), .sw_enable(sw_enable),
        .low_power(low_power), .inv_second(inv_second)
    );

    always #5 clk = ~clk;

    // Behavioural reference: 0 idle, 1 rising, 2 running, 3 falling
    int m_ph = 0, m_lvl = 0, m_cnt = 0;
    bit m_ramp = 0, m_inv = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_lvl = 0; m_cnt = 0; m_ramp = 0; m_inv = 0;
        end else begin
            case (m_ph)
                0: if (pair_rst_n) begin
                       m_inv  = cfg_code[2];
                       m_ramp = ramp_strap && cfg_code[1:0] == 2'b11;
                       m_cnt  = 0;
                       m_ph   = m_ramp ? 1 : 2;
                   end
                1: if (!pair_rst_n) begin m_ph = 3; m_cnt = 0; end
                   else begin
                       m_cnt++;
                       if (m_cnt == UPD) begin
                           m_cnt = 0; m_lvl++;
                           if (m_lvl == MID) m_ph = 2;
                       end
                   end
                2: if (!pair_rst_n) begin
                       if (m_ramp) begin m_ph = 3; m_cnt = 0; end
                       else begin m_ph = 0; m_lvl = 0; end
                   end
                default: if (pair_rst_n) begin m_ph = 1; m_cnt = 0; end
                   else if (m_lvl == 0) m_ph = 0;
                   else begin
                       m_cnt++;
                       if (m_cnt == DND) begin
                           m_cnt = 0; m_lvl--;
                           if (m_lvl == 0) m_ph = 0;
                       end
                   end
            endcase
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Model comparison on every clock, away from the edge
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            chk("R4/R6/R8 bias_level vs model", int'(bias_level), m_lvl);
            chk("R6/R7 out_drive vs model", int'(out_drive), int'(m_ph != 0));
            chk("R1 low_power vs model", int'(low_power), int'(m_ph == 0));
            chk("R5 sw_enable vs model", int'(sw_enable),
                int'(m_ph == 2 && pair_rst_n && mod_valid));
            chk("R2 inv_second vs model", int'(inv_second), int'(m_inv && m_ph != 0));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #3;
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(4);
        // R1: idle while the pair reset is held low, even with ramp selected
        cfg_code = 3'b111; ramp_strap = 1'b1; mod_valid = 1'b1;
        cyc(3);
        chk("R1 idle out_drive", int'(out_drive), 0);
        chk("R1 idle low_power", int'(low_power), 1);
        chk("R1 idle bias_level", int'(bias_level), 0);
        chk("R1 idle inv_second", int'(inv_second), 0);

        // R4: ramp up in code 111
        pair_rst_n = 1'b1;
        cyc(1);
        chk("R4 drive at ramp start", int'(out_drive), 1);
        chk("R4 level at ramp start", int'(bias_level), 0);
        chk("R2 inversion latched", int'(inv_second), 1);
        cfg_code = 3'b000; ramp_strap = 1'b0;   // R2: must be ignored now
        cyc(MID * UPD - 1);
        chk("R4 one step short of bias", int'(bias_level), MID - 1);
        chk("R5 no switching before bias", int'(sw_enable), 0);
        cyc(1);
        chk("R4 bias reached", int'(bias_level), MID);
        chk("R5 switching at bias", int'(sw_enable), 1);
        chk("R2 inversion held after cfg change", int'(inv_second), 1);
        mod_valid = 1'b0;
        #1;
        chk("R5 switching drops with mod_valid", int'(sw_enable), 0);
        #1 mod_valid = 1'b1;
        cyc(2);

        // R6 and R8: fall, reverse, fall to idle
        pair_rst_n = 1'b0;
        #1;
        chk("R5 switching drops with pair reset", int'(sw_enable), 0);
        cyc(11);
        chk("R6 level after two down steps", int'(bias_level), MID - 2);
        pair_rst_n = 1'b1;
        cyc(1);
        chk("R8 reversal keeps level", int'(bias_level), MID - 2);
        cyc(UPD);
        chk("R8 rises from current level", int'(bias_level), MID - 1);
        pair_rst_n = 1'b0;
        cyc(1 + (MID - 2) * DND);
        chk("R6 last level before idle", int'(bias_level), 1);
        chk("R6 still driving", int'(out_drive), 1);
        cyc(DND);
        chk("R6 high impedance at zero", int'(out_drive), 0);
        chk("R6 low power at zero", int'(low_power), 1);

        // R3 and R7: bypass with parallel code 110 (strap set)
        cfg_code = 3'b110; ramp_strap = 1'b1;
        cyc(2);
        pair_rst_n = 1'b1;
        cyc(1);
        chk("R7 immediate drive", int'(out_drive), 1);
        chk("R3 no ramp for code 110", int'(sw_enable), 1);
        chk("R3 level stays zero", int'(bias_level), 0);
        chk("R2 inversion from code 110", int'(inv_second), 1);
        pair_rst_n = 1'b0;
        cyc(1);
        chk("R7 immediate high impedance", int'(out_drive), 0);

        // R3: quad code 011 with strap cleared bypasses too
        cfg_code = 3'b011; ramp_strap = 1'b0;
        cyc(2);
        pair_rst_n = 1'b1;
        cyc(1);
        chk("R3 strap low bypasses", int'(sw_enable), 1);
        chk("R2 no inversion for code 011", int'(inv_second), 0);
        pair_rst_n = 1'b0;
        cyc(2);

        // R8: reversal at level zero reaches idle on the next edge
        cfg_code = 3'b011; ramp_strap = 1'b1;
        pair_rst_n = 1'b1;
        cyc(1);
        pair_rst_n = 1'b0;
        cyc(1);
        chk("R8 falling at zero still driving", int'(out_drive), 1);
        cyc(1);
        chk("R8 zero-level fall ends in idle", int'(low_power), 1);

        // R3: code 001 bypasses with strap set, mod_valid low blocks switching
        cfg_code = 3'b001; mod_valid = 1'b0;
        pair_rst_n = 1'b1;
        cyc(1);
        chk("R3 code 001 drives at once", int'(out_drive), 1);
        chk("R5 no switching without mod_valid", int'(sw_enable), 0);
        pair_rst_n = 1'b0;
        cyc(3);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule